// File: doc/BRIEF.md
# Decimal digit-selected CORDIC rotator

This block rotates a two-dimensional point whose coordinates are held as signed decimal fixed-point numbers. The rotation angle, in radians, is held in the same format. The arithmetic stays in BCD throughout and never converts to binary. The block iterates once per clock. In each step it keeps only the most significant nonzero decimal digit of the remaining angle, which gives a value t. That t serves as the tangent of the micro-rotation, so each coordinate update needs only one digit times a coordinate, followed by a decimal shift. The remaining angle then shrinks by arctan(t), taken from a small constant table. Because the step size follows the residual angle instead of a fixed schedule, no step ever has to be repeated, and the loop stops as soon as the angle is exactly zero.

A host loads x, y and z with a one-cycle start pulse. It waits for the single-cycle done pulse and then reads the rotated coordinates, which stay valid until the next start. The results carry the gain of every micro-rotation. The host removes that gain by multiplying by the product of cos(arctan(t)) over the digits used. The block applies no compensation of its own.

Top module: `dcr_rotator`

## Requirements
- R1: While reset is applied and afterwards until the first start, busy and done are 0 and x_out, y_out and z_out are all zero.
- R2: A start pulse seen while idle loads x_in, y_in and z_in. In the next cycle busy is 1 and the three outputs equal the loaded operands.
- R3: Each step takes t = d·10^-(e+1), where d is the first nonzero digit of |z| scanned from the 10^-1 digit downwards and e is the number of leading zero digits skipped (0 to 5). The step sets x to x − σ·p(y) and y to y + σ·p(x), where p(v) = floor(d·v / 10^(e+1)) in units of 10^-6.
- R4: Each step sets z to z − σ·A, where A is arctan(t) rounded to the nearest 10^-6. For e of 2 or more, A equals t.
- R5: σ is +1 when z is greater than zero and −1 when z is negative. A negative angle rotates clockwise and can make a coordinate negative.
- R6: Each operand is 7 BCD digits: bits 27:24 hold the units digit and bits 23:0 hold six fractional digits, with bits 3:0 the 10^-6 digit. Negative values are stored as ten's complement, so a units digit of 5 or more marks a negative value. Every output digit is a valid BCD digit. Angle inputs must lie in (−1, 1).
- R7: busy and done are never 1 together. In the cycle after z_out reads zero while busy, done is 1 for exactly one cycle and busy is 0.
- R8: A run performs at most MAX_ITER steps. If the angle has not reached zero by then, done pulses in the following cycle and the partial results are kept.
- R9: A start pulse while busy is ignored. The run in progress finishes with the results it would have had without that pulse.
- R10: If the loaded angle is zero, done pulses in the cycle after the load, and the coordinates equal the inputs.
- R11: While idle with start low, x_out, y_out and z_out do not change.
- R12: A start pulse in the same cycle that done is 1 is accepted, and the next run begins at once.
- R13: With x = 0.931420, y = 0.538504 and z = 0.785398, the run ends with z = 0, x within 20·10^-6 of 0.341669 and y within 20·10^-6 of 1.278205.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| start | input | 1 | One-cycle request to load operands and begin a run |
| x_in | input | 28 | Initial x coordinate, ten's-complement BCD |
| y_in | input | 28 | Initial y coordinate, ten's-complement BCD |
| z_in | input | 28 | Rotation angle in radians, ten's-complement BCD |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run has ended |
| x_out | output | 28 | Rotated x coordinate, still carrying the micro-rotation gain |
| y_out | output | 28 | Rotated y coordinate, still carrying the micro-rotation gain |
| z_out | output | 28 | Remaining angle |

## Verification
The end of a run and the acceptance of the next request can fall in the same cycle. When a run ends, done is high in a cycle where the control has already returned to idle, so a start in that cycle has to load new operands without disturbing the results just reported. The bench provokes this case by raising start in the very cycle it sees done. It then requires busy in the next cycle, loaded outputs equal to the new operands, and agreement with its own decimal model for the whole of both runs. The opposite case, a start that lands while a run is still stepping, is also provoked. It is judged by whether the final coordinates match what the model produces when it ignores that pulse.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef enum logic {ST_IDLE, ST_RUN} dcr_state_e;

  // nine's complement of one decimal digit
  function automatic bcd_t nines_of(input bcd_t d);
    return 4'd9 - d;
  endfunction

  // leading digit of a ten's-complement word marks a negative value
  function automatic logic digit_neg(input bcd_t d);
    return d >= 4'd5;
  endfunction
endpackage

// File: rtl/dcr_bcd_addsub.sv
`timescale 1ns/1ps
// Ten's-complement BCD adder/subtractor: res = a + b or a - b, modulo 10^NDIG.
module dcr_bcd_addsub
  import dcr_pkg::*;
#(
  parameter int NDIG = 7
) (
  input  logic [DIGIT_W*NDIG-1:0] a,
  input  logic [DIGIT_W*NDIG-1:0] b,
  input  logic                    sub,
  output logic [DIGIT_W*NDIG-1:0] res
);
  always_comb begin
    logic       carry;
    logic [4:0] dsum;
    bcd_t       bdig;
    carry = sub;
    res   = '0;
    for (int i = 0; i < NDIG; i++) begin
      bdig = sub ? nines_of(b[DIGIT_W*i +: DIGIT_W]) : b[DIGIT_W*i +: DIGIT_W];
      dsum = {1'b0, a[DIGIT_W*i +: DIGIT_W]} + {1'b0, bdig} + {4'd0, carry};
      if (dsum > 5'd9) begin
        res[DIGIT_W*i +: DIGIT_W] = 4'(dsum + 5'd6);
        carry = 1'b1;
      end else begin
        res[DIGIT_W*i +: DIGIT_W] = dsum[3:0];
        carry = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcr_lead_digit.sv
`timescale 1ns/1ps
// Finds the first nonzero fractional digit of |z| and its position.
module dcr_lead_digit
  import dcr_pkg::*;
#(
  parameter int NDIG = 7,
  parameter int EW   = 3
) (
  input  logic [DIGIT_W*NDIG-1:0] angle,
  output bcd_t                    lead,
  output logic [EW-1:0]           lead_pos,
  output logic                    angle_neg
);
  localparam int FRAC = NDIG - 1;
  localparam int W    = DIGIT_W * NDIG;

  logic [W-1:0] zero_w;
  logic [W-1:0] negated;
  logic [W-1:0] mag;

  assign zero_w    = '0;
  assign angle_neg = digit_neg(angle[W-1 -: DIGIT_W]);

  dcr_bcd_addsub #(.NDIG(NDIG)) u_negate (
    .a   (zero_w),
    .b   (angle),
    .sub (1'b1),
    .res (negated)
  );

  assign mag = angle_neg ? negated : angle;

  always_comb begin
    logic found;
    found    = 1'b0;
    lead     = '0;
    lead_pos = '0;
    for (int i = 0; i < FRAC; i++) begin
      if (!found && (mag[DIGIT_W*(FRAC-1-i) +: DIGIT_W] != '0)) begin
        found    = 1'b1;
        lead     = mag[DIGIT_W*(FRAC-1-i) +: DIGIT_W];
        lead_pos = EW'(i);
      end
    end
  end
endmodule

// File: rtl/dcr_digit_scale.sv
`timescale 1ns/1ps
// scaled = floor(coord * mult / 10^(pos+1)), ten's-complement BCD in and out.
module dcr_digit_scale
  import dcr_pkg::*;
#(
  parameter int NDIG = 7,
  parameter int EW   = 3
) (
  input  logic [DIGIT_W*NDIG-1:0] coord,
  input  bcd_t                    mult,
  input  logic [EW-1:0]           pos,
  output logic [DIGIT_W*NDIG-1:0] scaled
);
  localparam int PDIG = NDIG + 2;
  localparam int PW   = DIGIT_W * PDIG;

  logic [PW-1:0] ext;
  logic [PW-1:0] prod;
  bcd_t          fill;

  // sign-extend by two digits so a full-digit product cannot wrap
  always_comb begin
    ext = '0;
    ext[DIGIT_W*NDIG-1:0] = coord;
    for (int i = NDIG; i < PDIG; i++) begin
      ext[DIGIT_W*i +: DIGIT_W] = digit_neg(coord[DIGIT_W*NDIG-1 -: DIGIT_W]) ? 4'd9 : 4'd0;
    end
  end

  // digit-serial multiply with decimal carries
  always_comb begin
    logic [6:0] part;
    logic [3:0] cy;
    cy   = '0;
    prod = '0;
    for (int i = 0; i < PDIG; i++) begin
      part = 7'(ext[DIGIT_W*i +: DIGIT_W]) * 7'(mult) + 7'(cy);
      prod[DIGIT_W*i +: DIGIT_W] = 4'(part % 7'd10);
      cy   = 4'(part / 7'd10);
    end
  end

  assign fill = digit_neg(prod[PW-1 -: DIGIT_W]) ? 4'd9 : 4'd0;

  // arithmetic decimal shift right by pos+1 digits
  always_comb begin
    int src;
    scaled = '0;
    for (int i = 0; i < NDIG; i++) begin
      src = i + int'(pos) + 1;
      scaled[DIGIT_W*i +: DIGIT_W] = fill;
      for (int j = 0; j < PDIG; j++) begin
        if (j == src) scaled[DIGIT_W*i +: DIGIT_W] = prod[DIGIT_W*j +: DIGIT_W];
      end
    end
  end
endmodule

// File: rtl/dcr_atan_rom.sv
`timescale 1ns/1ps
// arctan(mult * 10^-(pos+1)) rounded to six fractional digits.
// For pos >= 2 the cubic term is below half an LSB, so the angle equals t.
module dcr_atan_rom
  import dcr_pkg::*;
#(
  parameter int NDIG = 7,
  parameter int EW   = 3
) (
  input  bcd_t                    mult,
  input  logic [EW-1:0]           pos,
  output logic [DIGIT_W*NDIG-1:0] angle
);
  localparam int FRAC = NDIG - 1;
  localparam int KW   = 24;

  logic [KW-1:0] coarse;

  always_comb begin
    coarse = '0;
    if (pos == EW'(0)) begin
      case (mult)
        4'd1:    coarse = 24'h099669;
        4'd2:    coarse = 24'h197396;
        4'd3:    coarse = 24'h291457;
        4'd4:    coarse = 24'h380506;
        4'd5:    coarse = 24'h463648;
        4'd6:    coarse = 24'h540420;
        4'd7:    coarse = 24'h610726;
        4'd8:    coarse = 24'h674741;
        4'd9:    coarse = 24'h732815;
        default: coarse = '0;
      endcase
    end else if (pos == EW'(1)) begin
      case (mult)
        4'd1:    coarse = 24'h010000;
        4'd2:    coarse = 24'h019997;
        4'd3:    coarse = 24'h029991;
        4'd4:    coarse = 24'h039979;
        4'd5:    coarse = 24'h049958;
        4'd6:    coarse = 24'h059928;
        4'd7:    coarse = 24'h069886;
        4'd8:    coarse = 24'h079830;
        4'd9:    coarse = 24'h089758;
        default: coarse = '0;
      endcase
    end
  end

  always_comb begin
    angle = '0;
    if (pos < EW'(2)) begin
      angle[DIGIT_W*FRAC-1 -: KW] = coarse;
    end else begin
      for (int j = 0; j < FRAC; j++) begin
        if (int'(pos) == FRAC - 1 - j) angle[DIGIT_W*j +: DIGIT_W] = mult;
      end
    end
  end
endmodule

// File: rtl/dcr_rotator.sv
`timescale 1ns/1ps
module dcr_rotator
  import dcr_pkg::*;
#(
  parameter int NDIG     = 7,
  parameter int MAX_ITER = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DIGIT_W*NDIG-1:0] x_in,
  input  logic [DIGIT_W*NDIG-1:0] y_in,
  input  logic [DIGIT_W*NDIG-1:0] z_in,
  output logic                    busy,
  output logic                    done,
  output logic [DIGIT_W*NDIG-1:0] x_out,
  output logic [DIGIT_W*NDIG-1:0] y_out,
  output logic [DIGIT_W*NDIG-1:0] z_out
);
  localparam int W  = DIGIT_W * NDIG;
  localparam int EW = $clog2(NDIG);
  localparam int CW = $clog2(MAX_ITER + 1);

  // reset: asserted at once, released two edges later
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  dcr_state_e     st_q, st_d;
  logic           done_q, done_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [W-1:0]   x_q, y_q, z_q;
  logic [W-1:0]   x_d, y_d, z_d;
  logic           load, step, dp_en;

  // datapath for one micro-rotation
  bcd_t           lead;
  logic [EW-1:0]  lead_pos;
  logic           z_neg;
  logic [W-1:0]   px, py, ang;
  logic [W-1:0]   x_step, y_step, z_step;
  logic           z_zero;

  dcr_lead_digit #(.NDIG(NDIG), .EW(EW)) u_lead (
    .angle     (z_q),
    .lead      (lead),
    .lead_pos  (lead_pos),
    .angle_neg (z_neg)
  );

  dcr_digit_scale #(.NDIG(NDIG), .EW(EW)) u_scale_x (
    .coord  (x_q),
    .mult   (lead),
    .pos    (lead_pos),
    .scaled (px)
  );

  dcr_digit_scale #(.NDIG(NDIG), .EW(EW)) u_scale_y (
    .coord  (y_q),
    .mult   (lead),
    .pos    (lead_pos),
    .scaled (py)
  );

  dcr_atan_rom #(.NDIG(NDIG), .EW(EW)) u_atan (
    .mult  (lead),
    .pos   (lead_pos),
    .angle (ang)
  );

  // positive angle: x - t*y, y + t*x, z - atan; negative angle flips each sign
  dcr_bcd_addsub #(.NDIG(NDIG)) u_add_x (
    .a (x_q), .b (py), .sub (!z_neg), .res (x_step)
  );

  dcr_bcd_addsub #(.NDIG(NDIG)) u_add_y (
    .a (y_q), .b (px), .sub (z_neg), .res (y_step)
  );

  dcr_bcd_addsub #(.NDIG(NDIG)) u_add_z (
    .a (z_q), .b (ang), .sub (!z_neg), .res (z_step)
  );

  assign z_zero = (z_q == '0);

  // control next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    load   = 1'b0;
    step   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_RUN;
          cnt_d = '0;
          load  = 1'b1;
        end
      end
      ST_RUN: begin
        if (z_zero || (cnt_q == CW'(MAX_ITER))) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          step  = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign dp_en = load | step;
  assign x_d   = load ? x_in : x_step;
  assign y_d   = load ? y_in : y_step;
  assign z_d   = load ? z_in : z_step;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      cnt_q <= '0;
    end else if (dp_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (dp_en) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  assign busy  = (st_q == ST_RUN);
  assign done  = done_q;
  assign x_out = x_q;
  assign y_out = y_q;
  assign z_out = z_q;
endmodule

// File: rtl/dcr_rotator_chk.sv
`timescale 1ns/1ps
module dcr_rotator_chk
  import dcr_pkg::*;
#(
  parameter int NDIG     = 7,
  parameter int MAX_ITER = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [DIGIT_W*NDIG-1:0] x_in,
  input logic [DIGIT_W*NDIG-1:0] y_in,
  input logic [DIGIT_W*NDIG-1:0] z_in,
  input logic                    busy,
  input logic                    done,
  input logic [DIGIT_W*NDIG-1:0] x_out,
  input logic [DIGIT_W*NDIG-1:0] y_out,
  input logic [DIGIT_W*NDIG-1:0] z_out
);
  localparam int W = DIGIT_W * NDIG;

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (v[DIGIT_W*i +: DIGIT_W] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // number of busy cycles already spent in the current run
  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7
  done_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (z_out == '0)) |=> (done && !busy));

  // R7
  done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && x_out == $past(x_in) && y_out == $past(y_in) && z_out == $past(z_in)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

  // R8
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len <= MAX_ITER));

  // R6
  bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_bcd(x_out) && all_bcd(y_out) && all_bcd(z_out));

  // R5
  z_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && z_out != '0 && !digit_neg(z_out[W-1 -: DIGIT_W])) |=> !digit_neg(z_out[W-1 -: DIGIT_W]));
endmodule

bind dcr_rotator dcr_rotator_chk #(.NDIG(NDIG), .MAX_ITER(MAX_ITER)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .x_in  (x_in),
  .y_in  (y_in),
  .z_in  (z_in),
  .busy  (busy),
  .done  (done),
  .x_out (x_out),
  .y_out (y_out),
  .z_out (z_out)
);

// File: tb/dcr_rotator_bench.sv
`timescale 1ns/1ps
package dcr_tb_pkg;
  localparam longint MOD  = 10000000;
  localparam longint HALF = 5000000;

  function automatic longint wrapv(input longint v);
    longint m;
    m = v % MOD;
    if (m < 0) m += MOD;
    if (m >= HALF) m -= MOD;
    return m;
  endfunction

  function automatic logic [27:0] enc(input longint v);
    longint m;
    logic [27:0] r;
    m = v % MOD;
    if (m < 0) m += MOD;
    for (int i = 0; i < 7; i++) begin
      r[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  function automatic longint dec(input logic [27:0] b);
    longint m, p;
    m = 0;
    p = 1;
    for (int i = 0; i < 7; i++) begin
      m += longint'(b[4*i +: 4]) * p;
      p *= 10;
    end
    if (m >= HALF) m -= MOD;
    return m;
  endfunction

  function automatic longint fdiv(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q -= 1;
    return q;
  endfunction
endpackage

// Behavioural decimal model of the rotation recurrence, integers in units of 1e-6.
module dcr_ref_model
  import dcr_tb_pkg::*;
#(
  parameter int CAP = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [27:0] x_in,
  input  logic [27:0] y_in,
  input  logic [27:0] z_in,
  output logic        busy,
  output logic        done,
  output logic [27:0] x_out,
  output logic [27:0] y_out,
  output logic [27:0] z_out
);
  longint xs, ys, zs;
  int     steps;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs = 0; ys = 0; zs = 0; steps = 0;
      busy = 0; done = 0;
    end else begin
      done = 0;
      if (!busy) begin
        if (start) begin
          xs = dec(x_in); ys = dec(y_in); zs = dec(z_in);
          steps = 0;
          busy = 1;
        end
      end else if (zs == 0 || steps == CAP) begin
        busy = 0;
        done = 1;
      end else begin
        longint mag, p, d, tv, pw, prx, pry, at, sg;
        int e;
        sg  = (zs > 0) ? 1 : -1;
        mag = (zs < 0) ? -zs : zs;
        p = 100000; e = 0;
        while (p > 0 && mag / p == 0) begin p = p / 10; e++; end
        d  = (p > 0) ? (mag / p) % 10 : 0;
        tv = d * p;
        pw = 1;
        for (int k = 0; k <= e; k++) pw *= 10;
        prx = fdiv(d * xs, pw);
        pry = fdiv(d * ys, pw);
        at  = longint'($rtoi($atan(real'(tv) / 1.0e6) * 1.0e6 + 0.5));
        xs = wrapv(xs - sg * pry);
        ys = wrapv(ys + sg * prx);
        zs = wrapv(zs - sg * at);
        steps++;
      end
    end
    x_out = enc(xs);
    y_out = enc(ys);
    z_out = enc(zs);
  end
endmodule

module dcr_rotator_bench;
  import dcr_tb_pkg::*;

  localparam int CAP_SMALL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] x_in = '0, y_in = '0, z_in = '0;

  logic        busy, done, m_busy, m_done;
  logic [27:0] x_out, y_out, z_out, mx, my, mz;
  logic        c_busy, c_done, cm_busy, cm_done;
  logic [27:0] cx, cy, cz, cmx, cmy, cmz;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dcr_rotator #(.NDIG(7), .MAX_ITER(12)) u_dcr_rotator (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out));

  dcr_rotator #(.NDIG(7), .MAX_ITER(CAP_SMALL)) u_dcr_rotator_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(c_busy), .done(c_done), .x_out(cx), .y_out(cy), .z_out(cz));

  dcr_ref_model #(.CAP(12)) u_model (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(m_busy), .done(m_done), .x_out(mx), .y_out(my), .z_out(mz));

  dcr_ref_model #(.CAP(CAP_SMALL)) u_model_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(cm_busy), .done(cm_done), .x_out(cmx), .y_out(cmy), .z_out(cmz));

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7", "busy", busy, m_busy);
      chk("R7", "done", done, m_done);
      chk("R3", "x", x_out, mx);
      chk("R3", "y", y_out, my);
      chk("R4", "z", z_out, mz);
      chk("R8", "cap busy", c_busy, cm_busy);
      chk("R8", "cap done", c_done, cm_done);
      chk("R8", "cap x", cx, cmx);
      chk("R8", "cap y", cy, cmy);
      chk("R8", "cap z", cz, cmz);
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    finish_run();
  end

  task automatic launch(input longint xv, input longint yv, input longint zv);
    x_in  = enc(xv);
    y_in  = enc(yv);
    z_in  = enc(zv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R7 done timeout: actual 0 expected 1");
    end
  endtask

  task automatic final_cmp(input string tag);
    chk(tag, "final x", x_out, mx);
    chk(tag, "final y", y_out, my);
    chk(tag, "final z", z_out, mz);
  endtask

  initial begin
    longint hx, hy, hz, xr, yr;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "x in reset", x_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "z after reset", z_out, 0);

    // R2 and R13: worked example, R8 on the capped instance
    launch(931420, 538504, 785398);
    chk("R2", "busy after load", busy, 1);
    chk("R2", "x loaded", x_out, enc(931420));
    chk("R2", "y loaded", y_out, enc(538504));
    chk("R2", "z loaded", z_out, enc(785398));
    repeat (3) @(negedge clk);
    chk("R8", "cap done after two steps", c_done, 1);
    chk("R8", "cap angle left nonzero", (cz != 0), 1);
    wait_done();
    final_cmp("R13");
    chk("R13", "z reaches zero", z_out, 0);
    xr = dec(x_out) - 341669;
    yr = dec(y_out) - 1278205;
    chk("R13", "x near 0.341669", (xr <= 20 && xr >= -20), 1);
    chk("R13", "y near 1.278205", (yr <= 20 && yr >= -20), 1);

    // R11: hold while idle
    hx = x_out; hy = y_out; hz = z_out;
    x_in = enc(111111); y_in = enc(222222); z_in = enc(333333);
    repeat (4) @(negedge clk);
    chk("R11", "x held", x_out, hx);
    chk("R11", "y held", y_out, hy);
    chk("R11", "z held", z_out, hz);

    // R10: zero angle
    launch(123456, 654321, 0);
    chk("R10", "busy", busy, 1);
    @(negedge clk);
    chk("R10", "done next cycle", done, 1);
    chk("R10", "x unchanged", x_out, enc(123456));
    chk("R10", "y unchanged", y_out, enc(654321));

    // R12: start in the done cycle
    launch(250000, 750000, 400000);
    chk("R12", "busy after back-to-back start", busy, 1);
    chk("R12", "z loaded back-to-back", z_out, enc(400000));
    wait_done();
    final_cmp("R12");

    // R9: start while busy is ignored
    launch(600000, 100000, 987654);
    x_in = enc(5); y_in = enc(5); z_in = enc(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    final_cmp("R9");
    @(negedge clk);

    // R5 and R6: negative angle makes y negative in ten's complement
    launch(1000000, 0, -500000);
    wait_done();
    final_cmp("R5");
    chk("R6", "y sign digit negative", (y_out[27:24] >= 4'd5), 1);
    chk("R5", "y below zero", (dec(y_out) < 0), 1);
    @(negedge clk);

    // random operands, mixed signs, R3 and R4
    for (int n = 0; n < 40; n++) begin
      longint xv, yv, zv;
      xv = longint'($urandom_range(0, 999999));
      yv = longint'($urandom_range(0, 999999));
      zv = longint'($urandom_range(0, 999999));
      if ($urandom_range(0, 1) == 1) zv = -zv;
      if ($urandom_range(0, 3) == 0) xv = -xv;
      launch(xv, yv, zv);
      wait_done();
      final_cmp("R3");
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule